// File: doc/BRIEF.md
# BRR ADPCM Sample Decoder

This block expands bit-rate-reduced audio packets into a stream of unsigned 8-bit samples. It reads compressed bytes one at a time from an upstream FIFO through a valid/ready port. It produces one output byte for each accepted sample request. A packet starts with a header byte and continues with 14 data bytes. Each data byte carries two 4-bit codes, low nibble first, so a packet yields 28 samples. The header chooses a right-shift amount for the codes and one of 16 coefficient pairs. The pair drives a second-order predictor that runs on the last two decoded samples. The 16-bit result is saturated, then reduced to an offset-binary byte.

A mode byte selects the function. When the mode selects decoding, the block decodes packets. Any other mode value makes it a plain pass-through that forwards one FIFO byte for each request. A software-loaded bank of 32 signed bytes holds the coefficients. A clear input, pulsed when the FIFO is flushed or the mode changes, drops the packet in progress and the prediction history.

Back-pressure rules are as follows. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. A byte leaves the FIFO only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` may rise while `in_valid` is low, and no byte is taken in that case. The output has no ready signal: each accepted request returns exactly one `smp_valid` pulse.

Top module: `brr_decoder`

## Requirements
- R1: During and after reset, `smp_valid` and `in_ready` are low, `req_ready` is high and `smp_data` is 0x80. The decoder waits for a header and both history samples are zero. Every coefficient reads as zero.
- R2: The block decodes when `mode_ctrl & 0x83 == 0x82`. For every other mode value, each request takes one FIFO byte and outputs it unchanged, or outputs 0x80 if the FIFO is empty.
- R3: When a header is needed, the first byte taken is the header. Bits 3:0 of the header give the shift and bits 7:4 give the filter index. No sample is emitted for the header cycle.
- R4: Even sample positions (0, 2, …) take a new data byte and use its bits 3:0. Odd positions use bits 7:4 of the byte already held and take nothing from the FIFO.
- R5: The code is placed in bits 15:12 of a signed 16-bit word. That word is then shifted right arithmetically by the header shift.
- R6: The prediction is (h0·f0 + h1·f1 + 32) >>> 6. Here h0 is the last decoded sample and h1 is the one before it. f0 is the signed coefficient at bank address 2·filter+1 and f1 is the one at 2·filter.
- R7: The shifted code plus the prediction saturates to −32768…32767. That value becomes h0, and the old h0 becomes h1.
- R8: The output byte is the saturated value divided by 256 (truncating toward zero), taken modulo 256, with bit 7 inverted.
- R9: After 28 samples the packet ends. The next request fetches a new header first.
- R10: If a byte is needed while `in_valid` is low, the output is 0x80. The sample position and the history do not change. A header already taken is kept.
- R11: A `dec_clear` pulse returns the decoder to waiting for a header and zeroes the history. A request raised in the same cycle as the clear is not accepted.
- R12: Each accepted request yields exactly one `smp_valid` pulse. The pulse comes one cycle after acceptance, or two cycles when a header is taken. `req_ready` stays low in between.
- R13: A coefficient write through `coef_we` takes effect for decoding from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ctrl | input | 8 | Mode byte (decode when masked 0x83 equals 0x82) |
| dec_clear | input | 1 | Drop the packet and the history |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 5 | Coefficient bank address |
| coef_wdata | input | 8 | Coefficient value (signed) |
| in_valid | input | 1 | FIFO holds a byte |
| in_data | input | 8 | Byte at the FIFO head |
| in_ready | output | 1 | Decoder takes the head byte when `in_valid` is high |
| req_valid | input | 1 | Sample request |
| req_ready | output | 1 | Request can be accepted |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_data | output | 8 | Offset-binary output sample |

## Verification
The clear input and a sample request can arrive in the same cycle. The bench raises both on one cycle edge in the middle of a packet. It then expects three things: `req_ready` low during that cycle, no sample pulse afterwards, and no FIFO byte taken. The following request must start a fresh packet from the next FIFO byte with zero history. The same reference model also judges a sweep over every shift and filter pair, so a clear that only partly resets the state shows up as mismatching samples later on.

// File: rtl/brr_pkg.sv
package brr_pkg;
  localparam logic [7:0] MODE_MASK = 8'h83;
  localparam logic [7:0] MODE_BRR  = 8'h82;
  localparam logic [7:0] SILENCE   = 8'h80;

  typedef enum logic {
    ST_IDLE     = 1'b0,
    ST_HDR_DONE = 1'b1
  } brr_st_e;
endpackage

// File: rtl/brr_coef_bank.sv
module brr_coef_bank #(
  parameter int NUM_FILT = 16,
  parameter int COEF_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [$clog2(NUM_FILT):0]     waddr,
  input  logic [COEF_W-1:0]             wdata,
  input  logic [$clog2(NUM_FILT)-1:0]   sel,
  output logic signed [COEF_W-1:0]      f0,
  output logic signed [COEF_W-1:0]      f1
);
  localparam int DEPTH = 2 * NUM_FILT;
  localparam int AW    = $clog2(NUM_FILT) + 1;

  logic [COEF_W-1:0] regs [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_coef
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs[i] <= '0;
      else if (we && waddr == AW'(i))      regs[i] <= wdata;
    end
  end

  // odd address feeds the newest-sample tap, even address the older one
  assign f0 = $signed(regs[{sel, 1'b1}]);
  assign f1 = $signed(regs[{sel, 1'b0}]);

  assert_coef_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/brr_predict.sv
module brr_predict #(
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 8,
  parameter int ROUND_SH = 6
) (
  input  logic [3:0]                  nib,
  input  logic [3:0]                  shift,
  input  logic signed [COEF_W-1:0]    f0,
  input  logic signed [COEF_W-1:0]    f1,
  input  logic signed [SAMPLE_W-1:0]  h0,
  input  logic signed [SAMPLE_W-1:0]  h1,
  output logic signed [SAMPLE_W-1:0]  sat_val,
  output logic [7:0]                  out_byte
);
  localparam int SUM_W = SAMPLE_W + COEF_W + 2;
  localparam logic signed [SUM_W-1:0] RND    = SUM_W'(1) << (ROUND_SH - 1);
  localparam logic signed [SUM_W-1:0] SAT_HI = (SUM_W'(1) << (SAMPLE_W - 1)) - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);
  localparam logic [SAMPLE_W-1:0]     LIM_HI = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0]     LIM_LO = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic signed [SAMPLE_W-1:0] scaled;
  logic signed [SUM_W-1:0]    x0, x1, c0, c1, acc, pred, sx, tsum;
  logic [7:0]                 q8;
  logic                       round_up;

  always_comb begin
    scaled = $signed({nib, {(SAMPLE_W-4){1'b0}}}) >>> shift;
    x0     = {{(SUM_W-SAMPLE_W){h0[SAMPLE_W-1]}}, h0};
    x1     = {{(SUM_W-SAMPLE_W){h1[SAMPLE_W-1]}}, h1};
    c0     = {{(SUM_W-COEF_W){f0[COEF_W-1]}}, f0};
    c1     = {{(SUM_W-COEF_W){f1[COEF_W-1]}}, f1};
    acc    = x0 * c0 + x1 * c1 + RND;
    pred   = acc >>> ROUND_SH;
    sx     = {{(SUM_W-SAMPLE_W){scaled[SAMPLE_W-1]}}, scaled};
    tsum   = sx + pred;
    if (tsum > SAT_HI)      sat_val = $signed(LIM_HI);
    else if (tsum < SAT_LO) sat_val = $signed(LIM_LO);
    else                    sat_val = $signed(tsum[SAMPLE_W-1:0]);
    // divide by 256 toward zero: floor plus one for negative values with a remainder
    q8       = sat_val[SAMPLE_W-1 -: 8];
    round_up = sat_val[SAMPLE_W-1] && (|sat_val[SAMPLE_W-9:0]);
    out_byte = (q8 + {7'd0, round_up}) ^ 8'h80;
  end
endmodule

// File: rtl/brr_decoder.sv
module brr_decoder
  import brr_pkg::*;
#(
  parameter int SAMPLES_PER_PKT = 28,
  parameter int NUM_FILT        = 16,
  parameter int SAMPLE_W        = 16,
  parameter int COEF_W          = 8,
  parameter int ROUND_SH        = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [7:0]                mode_ctrl,
  input  logic                      dec_clear,
  input  logic                      coef_we,
  input  logic [$clog2(NUM_FILT):0] coef_addr,
  input  logic [COEF_W-1:0]         coef_wdata,
  input  logic                      in_valid,
  input  logic [7:0]                in_data,
  output logic                      in_ready,
  input  logic                      req_valid,
  output logic                      req_ready,
  output logic                      smp_valid,
  output logic [7:0]                smp_data
);
  localparam int FILT_W = $clog2(NUM_FILT);
  localparam int CNT_W  = $clog2(SAMPLES_PER_PKT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLES_PER_PKT - 1);

  brr_st_e                    st_q;
  logic                       need_hdr_q;
  logic [CNT_W-1:0]           cnt_q;
  logic [7:0]                 hdr_q, dbyte_q;
  logic signed [SAMPLE_W-1:0] hist0_q, hist1_q;

  logic                       dec_mode, act, need_byte, take, hdr_take, calc, emit;
  logic [3:0]                 nib;
  logic [7:0]                 smp_next, dec_byte;
  logic signed [COEF_W-1:0]   f0, f1;
  logic signed [SAMPLE_W-1:0] sat_val;

  always_comb begin
    dec_mode  = (mode_ctrl & MODE_MASK) == MODE_BRR;
    act       = !dec_clear && ((st_q == ST_IDLE && req_valid) || st_q == ST_HDR_DONE);
    need_byte = act && (!dec_mode || need_hdr_q || !cnt_q[0]);
    take      = need_byte && in_valid;
    hdr_take  = take && dec_mode && need_hdr_q;
    calc      = act && dec_mode && !need_hdr_q && (cnt_q[0] || in_valid);
    emit      = act && !hdr_take;
    nib       = cnt_q[0] ? dbyte_q[7:4] : in_data[3:0];
    if (!dec_mode) smp_next = in_valid ? in_data : SILENCE;
    else           smp_next = calc ? dec_byte : SILENCE;
  end

  assign in_ready  = need_byte;
  assign req_ready = (st_q == ST_IDLE) && !dec_clear;

  brr_coef_bank #(.NUM_FILT(NUM_FILT), .COEF_W(COEF_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (coef_we),
    .waddr (coef_addr),
    .wdata (coef_wdata),
    .sel   (hdr_q[4 +: FILT_W]),
    .f0    (f0),
    .f1    (f1)
  );

  brr_predict #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ROUND_SH(ROUND_SH)) u_pred (
    .nib      (nib),
    .shift    (hdr_q[3:0]),
    .f0       (f0),
    .f1       (f1),
    .h0       (hist0_q),
    .h1       (hist1_q),
    .sat_val  (sat_val),
    .out_byte (dec_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      need_hdr_q <= 1'b1;
      cnt_q      <= '0;
      hdr_q      <= '0;
      dbyte_q    <= '0;
      hist0_q    <= '0;
      hist1_q    <= '0;
      smp_valid  <= 1'b0;
      smp_data   <= SILENCE;
    end else if (dec_clear) begin
      st_q       <= ST_IDLE;
      need_hdr_q <= 1'b1;
      cnt_q      <= '0;
      hist0_q    <= '0;
      hist1_q    <= '0;
      smp_valid  <= 1'b0;
    end else begin
      smp_valid <= emit;
      if (emit) smp_data <= smp_next;
      st_q <= hdr_take ? ST_HDR_DONE : ST_IDLE;
      if (hdr_take) begin
        hdr_q      <= in_data;
        need_hdr_q <= 1'b0;
        cnt_q      <= '0;
      end
      if (calc) begin
        hist1_q <= hist0_q;
        hist0_q <= sat_val;
        if (!cnt_q[0]) dbyte_q <= in_data;
        if (cnt_q == LAST) begin
          cnt_q      <= '0;
          need_hdr_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assert_hdr_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_take |=> (!smp_valid && !need_hdr_q && cnt_q == '0));

  assert_pos_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_empty_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (need_byte && dec_mode && !in_valid) |=>
      (smp_valid && smp_data == SILENCE && $stable(hist0_q) && $stable(cnt_q)));

  assert_clear_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_clear |=> (need_hdr_q && cnt_q == '0 && hist0_q == '0 && hist1_q == '0 && !smp_valid));

  assert_busy_no_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_take |=> !req_ready || dec_clear);
endmodule

// File: tb/brr_decoder_test.sv
`timescale 1ns/1ps
module brr_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mode_ctrl = 8'h82;
  logic       dec_clear = 1'b0;
  logic       coef_we = 1'b0;
  logic [4:0] coef_addr = '0;
  logic [7:0] coef_wdata = '0;
  logic       in_valid, in_ready, req_ready, smp_valid;
  logic [7:0] in_data, smp_data;
  logic       req_valid = 1'b0;

  always #2 clk = ~clk;

  // bench FIFO: written by the stimulus, drained by the decoder
  logic [7:0] fmem [256];
  logic [7:0] wr = '0, rd;
  assign in_valid = (wr != rd);
  assign in_data  = fmem[rd];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd <= '0;
    else if (in_valid && in_ready) rd <= rd + 8'd1;

  brr_decoder uut (
    .clk(clk), .rst_n(rst_n), .mode_ctrl(mode_ctrl), .dec_clear(dec_clear),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .req_valid(req_valid), .req_ready(req_ready),
    .smp_valid(smp_valid), .smp_data(smp_data));

  int total = 0, bad = 0;
  // reference model state
  int m_p0 = 0, m_p1 = 0, m_cnt = 0;
  bit m_need = 1'b1;
  logic [7:0] m_hdr = '0, m_byte = '0, m_rd = '0;
  int cf [32];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    fmem[wr] = b;
    wr = wr + 8'd1;
  endtask

  task automatic push_pkt(input logic [7:0] h);
    push(h);
    for (int i = 0; i < 14; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      push(lfsr[7:0]);
    end
  endtask

  task automatic model_clear();
    m_need = 1'b1; m_cnt = 0; m_p0 = 0; m_p1 = 0;
  endtask

  task automatic model_step(output logic [7:0] e, output int lat);
    int nib, d, pred, t, q, f0, f1;
    lat = 1;
    e = 8'h80;
    if ((mode_ctrl & 8'h83) != 8'h82) begin
      if (m_rd != wr) begin e = fmem[m_rd]; m_rd = m_rd + 8'd1; end
      return;
    end
    if (m_need) begin
      if (m_rd == wr) return;
      m_hdr = fmem[m_rd]; m_rd = m_rd + 8'd1;
      m_need = 1'b0; m_cnt = 0; lat = 2;
    end
    if (m_cnt % 2 == 0) begin
      if (m_rd == wr) return;
      m_byte = fmem[m_rd]; m_rd = m_rd + 8'd1;
      nib = int'(m_byte) % 16;
    end else begin
      nib = int'(m_byte) / 16;
    end
    if (nib >= 8) nib = nib - 16;
    d = (nib * 4096) >>> (int'(m_hdr) % 16);
    f0 = cf[2 * (int'(m_hdr) / 16) + 1];
    f1 = cf[2 * (int'(m_hdr) / 16)];
    pred = (m_p0 * f0 + m_p1 * f1 + 32) >>> 6;
    t = d + pred;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    m_p1 = m_p0; m_p0 = t;
    q = t / 256;
    e = 8'((q & 255) ^ 128);
    m_cnt++;
    if (m_cnt == 28) begin m_cnt = 0; m_need = 1'b1; end
  endtask

  task automatic do_req(input string tag);
    logic [7:0] e; int le; int n;
    while (!req_ready) @(negedge clk);
    model_step(e, le);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!smp_valid && n < 4) begin @(negedge clk); n++; end
    chk(tag, int'(smp_data), int'(e));
    chk((le == 2) ? "R9" : "R12", n, le);
    chk("R4", int'(rd), int'(m_rd));
  endtask

  task automatic wcoef(input int a, input int v);
    coef_we = 1'b1; coef_addr = 5'(a); coef_wdata = 8'(v);
    @(negedge clk);
    coef_we = 1'b0;
    cf[a] = int'($signed(8'(v)));
  endtask

  task automatic pulse_clear();
    dec_clear = 1'b1;
    @(negedge clk);
    dec_clear = 1'b0;
    model_clear();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) cf[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1", int'(smp_valid), 0);
    chk("R1", int'(in_ready), 0);
    chk("R1", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(smp_data), 8'h80);

    // coefficients still at reset value: prediction is pure rounding
    push_pkt(8'h52);
    for (int s = 0; s < 28; s++) do_req("R1");

    for (int k = 0; k < 16; k++) begin
      int a, b;
      a = (k * 45 + 7) % 256;
      b = (k * 91 + 200) % 256;
      if (k == 0)  begin a = 0;   b = 0;   end
      if (k == 14) begin a = 128; b = 128; end
      if (k == 15) begin a = 127; b = 127; end
      wcoef(2 * k + 1, a);
      wcoef(2 * k, b);
    end

    // sweep every filter and shift
    for (int fl = 0; fl < 16; fl++)
      for (int sh = 0; sh < 16; sh++) begin
        push_pkt(8'(fl * 16 + sh));
        for (int s = 0; s < 28; s++)
          do_req(fl == 0 ? "R5" : fl >= 14 ? "R7" : s == 0 ? "R3" : (s % 2 == 1) ? "R6" : "R8");
      end

    // starvation cases
    pulse_clear();
    do_req("R10");
    push(8'h3B);
    do_req("R10");
    push(8'h9C);
    do_req("R10");
    do_req("R4");
    do_req("R10");
    for (int i = 0; i < 13; i++) push(8'(i * 19 + 5));
    for (int s = 0; s < 26; s++) do_req("R10");

    // clear in mid-packet, then clear together with a request
    push_pkt(8'hF4);
    for (int s = 0; s < 5; s++) do_req("R11");
    pulse_clear();
    for (int s = 0; s < 4; s++) do_req("R11");
    begin
      logic [7:0] rd_before;
      rd_before = rd;
      dec_clear = 1'b1; req_valid = 1'b1;
      #0;
      chk("R11", int'(req_ready), 0);
      @(negedge clk);
      dec_clear = 1'b0; req_valid = 1'b0;
      model_clear();
      chk("R11", int'(smp_valid), 0);
      @(negedge clk);
      chk("R11", int'(smp_valid), 0);
      chk("R11", int'(rd), int'(rd_before));
    end
    for (int s = 0; s < 20; s++) do_req("R11");

    // coefficient rewrite is used by the very next packet
    while (!req_ready) @(negedge clk);
    for (int s = 0; s < 40 && m_rd != wr; s++) do_req("R13");
    pulse_clear();
    wcoef(7, 100);
    wcoef(6, 200);
    push_pkt(8'h33);
    for (int s = 0; s < 28; s++) do_req("R13");

    // pass-through modes
    mode_ctrl = 8'h80;
    push(8'h12); push(8'hFE); push(8'h80);
    for (int s = 0; s < 3; s++) do_req("R2");
    do_req("R2");
    mode_ctrl = 8'h03;
    push(8'h5A);
    do_req("R2");
    mode_ctrl = 8'hA2;
    pulse_clear();
    push_pkt(8'h21);
    for (int s = 0; s < 28; s++) do_req("R2");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule